// File: doc/BRIEF.md
# RGB Panel Pixel Serializer

This block sits between a pixel pipeline and the data pins of an LCD panel. It accepts one 24-bit RGB pixel at a time from a source through a ready/valid handshake. It places that pixel on the panel data bus either in one bus cycle as a full 24-bit word, or as a stream of 8-bit bytes spread over three or four bus cycles. A 4-bit format code picks the output form.

In the byte-serial forms, the order of the colour components is programmable. It can be set separately for odd and even panel lines. The block keeps track of line parity on its own. A frame-start strobe resets the count to line 1, and every falling edge of line-valid moves it on to the next line. Two of the formats spend a fourth cycle on a zero padding byte, which comes either before or after the colour bytes.

Format and order settings are captured only on the frame-start strobe. A frame therefore keeps one format from start to end.

Top module: `rgb_panel_serializer`

## Requirements
- R1: After reset the block is in 24-bit parallel form with R,G,B order and line parity odd. The bus carries the presented pixel unchanged, and pix_ready is high.
- R2: In parallel form (format code 0), bus_data equals pix_data in every cycle in which pix_valid is high, and pix_ready is high in every cycle. Both order settings have no effect.
- R3: Format code 8 sends each pixel as three beats on bus_data[7:0] in the selected component order. bus_data[23:8] is zero.
- R4: Format code 10 sends each pixel as four beats. The first beat is the byte 0x00, followed by the three colour bytes in the selected order.
- R5: Format code 11 sends each pixel as four beats. The three colour bytes come first in the selected order, and the fourth beat is 0x00.
- R6: Order code 0 sends R,G,B. Code 1 sends B,R,G. Code 2 sends G,B,R. R is pix_data[23:16], G is pix_data[15:8] and B is pix_data[7:0].
- R7: frame_start makes the next line line 1, which uses odd_order. Each falling edge of line_valid outside a frame_start cycle moves to the next line, so parity alternates and even lines use even_order.
- R8: Any format code other than 0, 8, 10 or 11 acts as parallel form. Order code 3 acts as R,G,B.
- R9: mode_sel, odd_order and even_order are captured only in a cycle with frame_start high. Changes at other times do not affect output until the next frame_start.
- R10: pix_ready is high only in the beat that carries the last byte of the current pixel. The beat position holds while pix_valid is low. bus_data is zero and bus_en is low while pix_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 4 | Output format code, captured at frame start |
| odd_order | input | 2 | Component order for odd lines, captured at frame start |
| even_order | input | 2 | Component order for even lines, captured at frame start |
| frame_start | input | 1 | Start-of-frame strobe |
| line_valid | input | 1 | High during the active part of a line |
| pix_data | input | 24 | Pixel, {R,G,B} |
| pix_valid | input | 1 | Source has a pixel on pix_data |
| pix_ready | output | 1 | Pixel is consumed in this cycle (last beat) |
| bus_data | output | 24 | Panel data bus |
| bus_en | output | 1 | Bus carries a valid beat |

## Verification
Pixels use three distinct component bytes, so every permutation and every misplaced padding byte shows up as a wrong value. Each format is run over several lines with different odd and even orders, which separates a parity that never toggles, or toggles at the wrong edge, from a correct one. Gaps in pix_valid in the middle of a pixel check that the beat position holds. Settings are changed in the middle of a frame, and undefined codes are applied, to confirm the capture point and the fallback decoding.

// File: rtl/rps_pkg.sv
package rps_pkg;
   localparam int MODE_W = 4;
   localparam int ORD_W  = 2;
   localparam int NCOMP  = 3;
   localparam int BEAT_W = 2;

   typedef enum logic [1:0] {
      FMT_PAR       = 2'd0,
      FMT_SER3      = 2'd1,
      FMT_PAD_FIRST = 2'd2,
      FMT_PAD_LAST  = 2'd3
   } fmt_e;

   typedef enum logic [1:0] {
      ORD_RGB = 2'd0,
      ORD_BRG = 2'd1,
      ORD_GBR = 2'd2
   } ord_e;

   function automatic fmt_e fmt_decode(input logic [MODE_W-1:0] code);
      case (code)
         4'd8:    return FMT_SER3;
         4'd10:   return FMT_PAD_FIRST;
         4'd11:   return FMT_PAD_LAST;
         default: return FMT_PAR;
      endcase
   endfunction

   function automatic ord_e ord_decode(input logic [ORD_W-1:0] code);
      case (code)
         2'd1:    return ORD_BRG;
         2'd2:    return ORD_GBR;
         default: return ORD_RGB;
      endcase
   endfunction

   function automatic logic [BEAT_W-1:0] last_beat_of(input fmt_e f);
      case (f)
         FMT_PAR:  return 2'd0;
         FMT_SER3: return 2'd2;
         default:  return 2'd3;
      endcase
   endfunction

   // rotation applied to the slot index to reach the component index
   function automatic logic [1:0] ord_shift(input ord_e o);
      case (o)
         ORD_BRG: return 2'd2;
         ORD_GBR: return 2'd1;
         default: return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/rps_frame_ctrl.sv
module rps_frame_ctrl
   import rps_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              line_valid,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [ORD_W-1:0]  odd_order,
   input  logic [ORD_W-1:0]  even_order,
   output fmt_e              fmt,
   output ord_e              cur_ord,
   output logic              odd_line
);
   ord_e odd_ord_q, even_ord_q;
   logic lv_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt        <= FMT_PAR;
         odd_ord_q  <= ORD_RGB;
         even_ord_q <= ORD_RGB;
         odd_line   <= 1'b1;
         lv_d       <= 1'b0;
      end else begin
         lv_d <= line_valid;
         if (frame_start) begin
            fmt        <= fmt_decode(mode_sel);
            odd_ord_q  <= ord_decode(odd_order);
            even_ord_q <= ord_decode(even_order);
            odd_line   <= 1'b1;
         end else if (lv_d && !line_valid) begin
            odd_line <= ~odd_line;
         end
      end
   end

   assign cur_ord = odd_line ? odd_ord_q : even_ord_q;
endmodule

// File: rtl/rps_beat_ctrl.sv
module rps_beat_ctrl
   import rps_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              pix_valid,
   input  fmt_e              fmt,
   output logic [BEAT_W-1:0] beat,
   output logic              pix_ready
);
   logic [BEAT_W-1:0] last;

   assign last      = last_beat_of(fmt);
   assign pix_ready = (beat == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat <= '0;
      end else if (frame_start) begin
         beat <= '0;
      end else if (pix_valid) begin
         beat <= pix_ready ? '0 : beat + 1'b1;
      end
   end
endmodule

// File: rtl/rps_comp_mux.sv
module rps_comp_mux
   import rps_pkg::*;
#(
   parameter int CW = 8,
   localparam int BUS_W = CW * NCOMP
) (
   input  logic [BUS_W-1:0]  pix,
   input  logic              valid,
   input  fmt_e              fmt,
   input  ord_e              ord,
   input  logic [BEAT_W-1:0] beat,
   output logic [BUS_W-1:0]  bus
);
   logic [CW-1:0] comp [NCOMP];

   // component 0 is red, held in the most significant field
   for (genvar i = 0; i < NCOMP; i++) begin : g_split
      assign comp[i] = pix[(NCOMP-1-i)*CW +: CW];
   end

   logic [1:0] slot, idx;
   logic [2:0] sum;
   logic       pad;

   always_comb begin
      pad  = 1'b0;
      slot = beat;
      case (fmt)
         FMT_PAD_FIRST: begin
            pad  = (beat == 2'd0);
            slot = beat - 2'd1;
         end
         FMT_PAD_LAST: pad = (beat == 2'd3);
         default: ;
      endcase
      sum = {1'b0, slot} + {1'b0, ord_shift(ord)};
      idx = (sum >= 3'd3) ? 2'(sum - 3'd3) : sum[1:0];
   end

   always_comb begin
      bus = '0;
      if (valid) begin
         if (fmt == FMT_PAR)
            bus = pix;
         else if (!pad)
            bus[CW-1:0] = comp[idx];
      end
   end
endmodule

// File: rtl/rgb_panel_serializer.sv
module rgb_panel_serializer
   import rps_pkg::*;
#(
   parameter int CW = 8,
   localparam int BUS_W = CW * NCOMP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode_sel,
   input  logic [ORD_W-1:0]  odd_order,
   input  logic [ORD_W-1:0]  even_order,
   input  logic              frame_start,
   input  logic              line_valid,
   input  logic [BUS_W-1:0]  pix_data,
   input  logic              pix_valid,
   output logic              pix_ready,
   output logic [BUS_W-1:0]  bus_data,
   output logic              bus_en
);
   if (CW < 1) begin : g_bad_cw
      $error("rgb_panel_serializer: CW must be at least 1");
   end

   fmt_e              fmt_q;
   ord_e              ord_now;
   logic              odd_line;
   logic [BEAT_W-1:0] beat;

   rps_frame_ctrl u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .line_valid (line_valid),
      .mode_sel   (mode_sel),
      .odd_order  (odd_order),
      .even_order (even_order),
      .fmt        (fmt_q),
      .cur_ord    (ord_now),
      .odd_line   (odd_line)
   );

   rps_beat_ctrl u_beat (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .pix_valid  (pix_valid),
      .fmt        (fmt_q),
      .beat       (beat),
      .pix_ready  (pix_ready)
   );

   rps_comp_mux #(.CW(CW)) u_mux (
      .pix  (pix_data),
      .valid(pix_valid),
      .fmt  (fmt_q),
      .ord  (ord_now),
      .beat (beat),
      .bus  (bus_data)
   );

   assign bus_en = pix_valid;
endmodule

// File: rtl/rps_checker.sv
module rps_checker
   import rps_pkg::*;
#(
   parameter int CW = 8,
   localparam int BUS_W = CW * NCOMP
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              line_valid,
   input logic              pix_valid,
   input logic              pix_ready,
   input logic [BUS_W-1:0]  bus_data,
   input fmt_e              fmt,
   input logic [BEAT_W-1:0] beat,
   input logic              odd_line
);
   logic lv_q;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) lv_q <= 1'b0;
      else        lv_q <= line_valid;

   assert_par_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_PAR) |-> pix_ready);

   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt != FMT_PAR) |-> (bus_data[BUS_W-1:CW] == '0));

   assert_pad_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_PAD_FIRST && pix_valid && beat == '0) |-> (bus_data == '0));

   assert_pad_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt == FMT_PAD_LAST && pix_valid && pix_ready) |-> (bus_data == '0));

   assert_frame_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> odd_line);

   assert_line_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (lv_q && !line_valid && !frame_start) |=> (odd_line != $past(odd_line)));

   assert_ready_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt != FMT_PAR && pix_valid && pix_ready && !frame_start) |=> !pix_ready);

   assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid |-> (bus_data == '0));
endmodule

bind rgb_panel_serializer rps_checker #(.CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_start(frame_start),
   .line_valid (line_valid),
   .pix_valid  (pix_valid),
   .pix_ready  (pix_ready),
   .bus_data   (bus_data),
   .fmt        (fmt_q),
   .beat       (beat),
   .odd_line   (odd_line)
);

// File: tb/rgb_panel_serializer_tb.sv
module rgb_panel_serializer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  mode_sel = '0;
   logic [1:0]  odd_order = '0, even_order = '0;
   logic        frame_start = 1'b0, line_valid = 1'b0, pix_valid = 1'b0;
   logic [23:0] pix_data = '0;
   logic        pix_ready, bus_en;
   logic [23:0] bus_data;

   always #2 clk = ~clk;

   rgb_panel_serializer u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .odd_order(odd_order),
      .even_order(even_order), .frame_start(frame_start), .line_valid(line_valid),
      .pix_data(pix_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
      .bus_data(bus_data), .bus_en(bus_en)
   );

   int total = 0, bad = 0;
   string cur_req = "R1";

   // reference model state
   int m_mode = 0, m_oo = 0, m_eo = 0, m_beat = 0;
   bit m_odd = 1, m_lvd = 0;

   function automatic int nbeats(int md);
      if (md == 8) return 3;
      if (md == 10 || md == 11) return 4;
      return 1;
   endfunction

   function automatic logic [23:0] ref_bus(int md, int ord, int bt, logic [23:0] px);
      logic [7:0] r, g, b;
      int p;
      r = px[23:16]; g = px[15:8]; b = px[7:0];
      if (md == 0) return px;
      p = bt;
      if (md == 10) begin
         if (bt == 0) return 24'h0;
         p = bt - 1;
      end
      if (md == 11 && bt == 3) return 24'h0;
      case (ord)
         1: return (p == 0) ? {16'h0, b} : (p == 1) ? {16'h0, r} : {16'h0, g};
         2: return (p == 0) ? {16'h0, g} : (p == 1) ? {16'h0, b} : {16'h0, r};
         default: return (p == 0) ? {16'h0, r} : (p == 1) ? {16'h0, g} : {16'h0, b};
      endcase
   endfunction

   task automatic chk(string what, logic [23:0] act, logic [23:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic step(input bit fs, input bit lv, input bit pv,
                       input logic [23:0] px, output bit rdy);
      logic [23:0] eb;
      @(negedge clk);
      frame_start = fs; line_valid = lv; pix_valid = pv; pix_data = px;
      #1;
      eb = pv ? ref_bus(m_mode, m_odd ? m_oo : m_eo, m_beat, px) : 24'h0;
      chk("bus_data", bus_data, eb);
      chk("bus_en", {23'h0, bus_en}, {23'h0, pv});
      chk("pix_ready", {23'h0, pix_ready}, {23'h0, (m_beat == nbeats(m_mode) - 1)});
      rdy = pix_ready;
      @(posedge clk);
      if (fs) begin
         m_mode = (mode_sel == 8 || mode_sel == 10 || mode_sel == 11) ? int'(mode_sel) : 0;
         m_oo = (odd_order == 3) ? 0 : int'(odd_order);
         m_eo = (even_order == 3) ? 0 : int'(even_order);
         m_odd = 1;
         m_beat = 0;
      end else begin
         if (m_lvd && !lv) m_odd = !m_odd;
         if (pv) m_beat = (m_beat == nbeats(m_mode) - 1) ? 0 : m_beat + 1;
      end
      m_lvd = lv;
   endtask

   // one pixel, optionally with an idle cycle after the first beat (R10)
   task automatic send_px(logic [23:0] px, bit gap);
      bit rdy;
      int n = 0;
      do begin
         step(0, 1, 1, px, rdy);
         n++;
         if (gap && n == 1 && !rdy) step(0, 1, 0, 24'h0, rdy);
      end while (!rdy && n < 8);
   endtask

   task automatic new_frame(logic [3:0] md, logic [1:0] oo, logic [1:0] eo);
      bit rdy;
      mode_sel = md; odd_order = oo; even_order = eo;
      step(1, 0, 0, 24'h0, rdy);
   endtask

   task automatic run_line(int npx, logic [23:0] seed);
      bit rdy;
      for (int i = 0; i < npx; i++) send_px(seed + 24'h030507 * i, i == 0);
      step(0, 0, 0, 24'h0, rdy);
   endtask

   bit done = 0;
   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      bit rdy;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, parallel pass-through and ready high
      cur_req = "R1";
      step(0, 0, 1, 24'hA56B3C, rdy);
      step(0, 0, 0, 24'h0, rdy);
      // R9: serial settings presented without frame start are not taken
      cur_req = "R9";
      mode_sel = 4'd8; odd_order = 2'd1;
      run_line(2, 24'h112233);
      // R2: parallel form ignores the order settings
      cur_req = "R2";
      new_frame(4'd0, 2'd1, 2'd2);
      run_line(3, 24'hC0FFEE);
      // R3/R6/R7: three-beat form with differing odd/even orders
      cur_req = "R3";
      new_frame(4'd8, 2'd1, 2'd2);
      run_line(2, 24'h102030);
      cur_req = "R7";
      run_line(2, 24'h405060);
      run_line(1, 24'h708090);
      // R9: mid-frame changes have no effect
      cur_req = "R9";
      mode_sel = 4'd11; odd_order = 2'd0; even_order = 2'd1;
      run_line(2, 24'hA1B2C3);
      cur_req = "R6";
      new_frame(4'd8, 2'd0, 2'd1);
      run_line(2, 24'h0A0B0C);
      run_line(2, 24'hD1E2F3);
      // R4: padding byte first
      cur_req = "R4";
      new_frame(4'd10, 2'd2, 2'd0);
      run_line(2, 24'h123456);
      run_line(2, 24'h9ABCDE);
      // R5: padding byte last
      cur_req = "R5";
      new_frame(4'd11, 2'd1, 2'd2);
      run_line(2, 24'h654321);
      run_line(2, 24'h0F1E2D);
      // R8: undefined codes fall back
      cur_req = "R8";
      new_frame(4'd5, 2'd3, 2'd3);
      run_line(2, 24'h77AA55);
      new_frame(4'd8, 2'd3, 2'd3);
      run_line(2, 24'h3C5A78);
      run_line(1, 24'h8899AA);
      // R10: idle cycles between pixels keep the bus at zero
      cur_req = "R10";
      step(0, 1, 0, 24'hFFFFFF, rdy);
      send_px(24'h246810, 1);
      step(0, 0, 0, 24'hFFFFFF, rdy);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule